// File: doc/BRIEF.md
# SPI Slave Pause-and-Resume Front End

This block sits between the pins of an SPI slave and its shift core. It lets the bus master pause a transaction that is under way without ending it. While the block is paused, clock edges on the serial clock are not passed on and the serial data input is masked to zero. The output driver enable toward the core's data-out pin is also withdrawn. When the pause ends, shifting continues at the bit position where it stopped.

The pause request is an active-low pin. It is only acted on while the chip select (active low) is asserted. The block samples every pin on a fast system clock and finds the serial clock edges from one registered copy of that clock. The pause state changes only in system clock cycles where the serial clock is seen low. A pause request that arrives while the serial clock is high therefore waits for that clock's next falling edge. The block holds the bit position and the received word itself, so the core sees a plain shift strobe.

Top module: `spi_hold_gate`

## Requirements
- R1: Under reset, `in_hold` is 0, `bit_cnt` is 0, `rx_data` is 0 and `so_oe` is 0.
- R2: A rising SCK edge is detected in the system clock cycle where `sck` is 1 and was 0 in the cycle before. When such an edge arrives while selected (`ce_n`=0) and not in hold, `shift_en` is 1 for that cycle. At the next clock, `si` is shifted into bit 0 of `rx_data` (the older bits move toward the MSB) and `bit_cnt` goes up by one. After BITS edges `bit_cnt` wraps to 0.
- R3: At a clock where `ce_n`=0, `sck`=0 and `hold_n`=0, the block enters hold. `in_hold` reads 1 from the next cycle.
- R4: At a clock where `ce_n`=0, `sck`=0 and `hold_n`=1, the block leaves hold. `in_hold` reads 0 from the next cycle.
- R5: While `sck` is 1, a change on `hold_n` has no effect. It takes effect at the first clock where `sck` is seen low.
- R6: In hold, SCK edges cause no shift: `shift_en` stays 0, and `bit_cnt` and `rx_data` keep their values.
- R7: `si_gated` equals `si` while selected and not in hold. Otherwise it is 0.
- R8: `so_oe` is 1 only when `core_so_act` is 1, `ce_n` is 0 and the block is not in hold.
- R9: A clock with `ce_n`=1 clears the hold state and sets `bit_cnt` to 0. SCK edges while deselected shift nothing, so `rx_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock level, already synchronized |
| hold_n | input | 1 | Pause request, active low |
| si | input | 1 | Serial data in |
| core_so_act | input | 1 | Core wants to drive serial data out |
| shift_en | output | 1 | One-cycle strobe on each accepted rising SCK edge |
| si_gated | output | 1 | Serial data in, masked during hold or deselect |
| so_oe | output | 1 | Output enable for the serial data-out driver |
| in_hold | output | 1 | Pause state |
| bit_cnt | output | $clog2(BITS) | Bit position within the current word |
| rx_data | output | BITS | Received shift register |

## Verification
The bench builds the block with the default word of BITS = 8. With that width the bit counter wrap is reached after eight SCK edges, and a short vector table can cover a whole pause and resume. The table places pause and release requests both while SCK is low and while SCK is high. It also toggles SCK inside a pause and drops the chip select in the middle of a pause. Directed tests then cover a reset taken during a pause, the counter wrap, SI masking, and SCK edges while deselected.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int BITS = 8,
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            sck,
  input  logic            hold_n,
  input  logic            si,
  input  logic            core_so_act,
  output logic            shift_en,
  output logic            si_gated,
  output logic            so_oe,
  output logic            in_hold,
  output logic [CW-1:0]   bit_cnt,
  output logic [BITS-1:0] rx_data
);

  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic sck_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  // pause state moves only while SCK is seen low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= 1'b0;
    else if (ce_n) hold_q <= 1'b0;
    else if (!sck) hold_q <= ~hold_n;
  end

  assign shift_en = sck & ~sck_q & ~ce_n & ~hold_q;
  assign si_gated = si & ~ce_n & ~hold_q;
  assign so_oe    = core_so_act & ~ce_n & ~hold_q;
  assign in_hold  = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bit_cnt <= '0;
    else if (ce_n)     bit_cnt <= '0;
    else if (shift_en) bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
  end

  generate
    if (BITS > 1) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_data <= '0;
        else if (shift_en) rx_data <= {rx_data[BITS-2:0], si};
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_data <= '0;
        else if (shift_en) rx_data <= si;
      end
    end
  endgenerate

  p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !sck && !hold_n) |=> in_hold);

  p_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !sck && hold_n) |=> !in_hold);

  p_sck_high_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && sck) |=> $stable(in_hold));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !ce_n) |=> ($stable(bit_cnt) && $stable(rx_data)));

  p_deselect_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!in_hold && bit_cnt == '0 && $stable(rx_data)));

  p_oe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> (!so_oe && !shift_en && !si_gated));

endmodule

// File: tb/sim_spi_hold_gate.sv
module sim_spi_hold_gate;
  localparam int PERIOD = 10;
  localparam int BITS = 8;
  localparam int CW = $clog2(BITS);
  localparam int NV = 16;
  // {ce_n, sck, hold_n, si, act, exp_hold, exp_cnt[2:0], exp_oe}
  localparam logic [9:0] VEC [NV] = '{
    10'b1_0_1_0_0_0_000_0,
    10'b0_0_1_1_1_0_000_1,
    10'b0_1_1_1_1_0_001_1,
    10'b0_0_1_0_1_0_001_1,
    10'b0_1_1_0_1_0_010_1,
    10'b0_0_0_1_1_1_010_0,
    10'b0_1_0_1_1_1_010_0,
    10'b0_0_0_1_1_1_010_0,
    10'b0_1_1_1_1_1_010_0,
    10'b0_0_1_1_1_0_010_1,
    10'b0_1_1_1_1_0_011_1,
    10'b0_1_0_0_1_0_011_1,
    10'b0_0_0_0_1_1_011_0,
    10'b1_0_0_0_1_0_000_0,
    10'b0_0_1_0_0_0_000_0,
    10'b0_1_1_1_0_0_001_0
  };

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, sck = 0, hold_n = 1, si = 0, core_so_act = 0;
  logic shift_en, si_gated, so_oe, in_hold;
  logic [CW-1:0] bit_cnt;
  logic [BITS-1:0] rx_data;
  int tests = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_hold_gate #(.BITS(BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sck(sck), .hold_n(hold_n),
    .si(si), .core_so_act(core_so_act), .shift_en(shift_en),
    .si_gated(si_gated), .so_oe(so_oe), .in_hold(in_hold),
    .bit_cnt(bit_cnt), .rx_data(rx_data));

  function automatic string row_tag(int i);
    case (i)
      0: return "R1";
      1, 2, 3, 4: return "R2";
      5: return "R3";
      6, 7: return "R6";
      8: return "R5";
      9: return "R4";
      10: return "R2";
      11, 12: return "R5";
      13: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(logic c, logic k, logic h, logic d, logic a);
    @(negedge clk);
    ce_n = c; sck = k; hold_n = h; si = d; core_so_act = a;
    @(posedge clk); #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 hold", int'(in_hold), 0);
    check("R1 cnt", int'(bit_cnt), 0);
    check("R1 rx", int'(rx_data), 0);
    check("R1 oe", int'(so_oe), 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      check({row_tag(i), " hold"}, int'(in_hold), int'(VEC[i][4]));
      check({row_tag(i), " cnt"}, int'(bit_cnt), int'(VEC[i][3:1]));
      check({row_tag(i), " oe"}, int'(so_oe), int'(VEC[i][0]));
    end
    check("R6 rx bits kept across pause", int'(rx_data), 8'h0B);

    // R9: SCK edges while deselected shift nothing
    step(1, 0, 1, 1, 0);
    step(1, 1, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    check("R9 rx deselected", int'(rx_data), 8'h0B);
    check("R9 cnt deselected", int'(bit_cnt), 0);

    // R7: SI masking
    step(0, 0, 1, 1, 0);
    check("R7 si passes", int'(si_gated), 1);
    step(0, 0, 0, 1, 0);
    check("R7 si masked in hold", int'(si_gated), 0);
    step(1, 0, 1, 1, 0);
    check("R7 si masked deselected", int'(si_gated), 0);

    // R2: wrap after BITS edges, rx takes all ones
    step(0, 0, 1, 1, 0);
    for (int b = 0; b < BITS; b++) begin
      step(0, 1, 1, 1, 0);
      step(0, 0, 1, 1, 0);
    end
    check("R2 cnt wraps", int'(bit_cnt), 0);
    check("R2 rx filled", int'(rx_data), 8'hFF);

    // R1: reset during a pause
    step(0, 1, 1, 0, 1);
    step(0, 0, 0, 0, 1);
    check("R3 entered before reset", int'(in_hold), 1);
    @(negedge clk); rst_n = 0;
    #1;
    check("R1 hold after reset", int'(in_hold), 0);
    check("R1 cnt after reset", int'(bit_cnt), 0);
    check("R1 rx after reset", int'(rx_data), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule